// File: doc/BRIEF.md
# Edge-Event Counter and Pulse-Capture Timer

This block is one 16-bit timer channel with two working modes, chosen by a mode register. In event mode the counter steps down once for each selected transition of an asynchronous external input. When a step would take it below zero, it reloads from a reload register and raises an interrupt pulse.

In measurement mode the counter steps up on one of four prescaled clock enables. When a qualifying input transition arrives, the block copies the running count into a buffer register, clears the counter and raises an interrupt pulse. The qualifying transitions can be falling-to-falling, rising-to-rising, or every transition, which gives width measurement. The first capture after each start is a phase-alignment capture and raises no interrupt.

Software drives the block through a small register port with three addresses: mode, data and start. A control state machine has four states. ST_IDLE means stopped. ST_EVENT means counting edges. ST_ARMED means a measurement has started and is waiting for its first capture. ST_MEASURE means the block is measuring and reporting. The transitions are:
- ST_IDLE goes to ST_EVENT (start with event mode) or to ST_ARMED (start with measurement mode).
- ST_ARMED goes to ST_MEASURE on the first capture.
- Any state returns to ST_IDLE when the start flag is cleared, or when the mode field no longer matches the running state.

Top module: `pulse_capture_timer`

## Requirements
- R1: After reset the mode, data and start reads return 0, and both irq and ovf are 0.
- R2: While the start flag (address 2, bit 0) is 0, the counter does not count. A write to address 1 loads both the reload register and the counter, and the address-1 read then returns that value.
- R3: Mode field bits 1:0 = 01 selects event mode. In event mode, bits 3:2 choose the counted transition: 00 falling, 01 rising, 10 both, 11 none. The counter decrements by one per counted transition, and the address-1 read returns the live counter.
- R4: In event mode, a counted transition with the counter at 0 reloads the counter from the reload register and pulses irq for one cycle.
- R5: Mode field bits 1:0 = 10 selects measurement mode. Bits 7:6 = k select prescale enable pre_en[k] as the count tick, and the other enables have no effect.
- R6: In measurement mode with bit 3 = 0, captures happen on falling edges when bit 2 = 0 and on rising edges when bit 2 = 1.
- R7: In measurement mode with bit 3 = 1, every input transition is a capture, so the buffer holds each high or low width.
- R8: On a capture, the counter value is copied into the buffer register (the address-1 read in measurement mode) and the counter is cleared to 0.
- R9: The first capture after the start flag is set raises no irq. Every later capture pulses irq once.
- R10: If the measurement counter wraps from 16'hFFFF to 0, ovf sets, and it reads back as bit 5 of address 0. It stays set until the next write to address 0.
- R11: An input change takes effect at the third rising clock edge after it, because it passes a two-flop synchronizer and an edge detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 mode, 1 data, 2 start |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for reg_addr (combinational) |
| ext_in | input | 1 | Asynchronous external signal |
| pre_en | input | 4 | Prescaled clock enables, one-cycle pulses |
| irq | output | 1 | One-cycle interrupt request pulse |
| ovf | output | 1 | Sticky measurement overflow flag |

## Verification
A wrong state shows up at the ports within a few cycles. A channel stuck in ST_ARMED never raises irq. One that skips ST_ARMED raises an irq on the very first capture. A stale counter shows up as a wrong buffer value at the capture that follows the error. A wrong edge choice or prescale choice changes the read-back count after a single pulse train. A counter that was not cleared inflates the next capture, so each measurement run checks two captures in a row.

// File: rtl/pct_pkg.sv
package pct_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_EVENT   = 2'd1,
        ST_ARMED   = 2'd2,
        ST_MEASURE = 2'd3
    } pct_state_e;

    localparam logic [1:0] MODE_EVENT = 2'b01;
    localparam logic [1:0] MODE_MEAS  = 2'b10;

    localparam logic [1:0] ADDR_MODE  = 2'd0;
    localparam logic [1:0] ADDR_DATA  = 2'd1;
    localparam logic [1:0] ADDR_START = 2'd2;

    localparam int OVF_BIT = 5;
endpackage

// File: rtl/pct_edge_sync.sv
module pct_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~last_q;
    assign fall = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/pct_tick_sel.sv
module pct_tick_sel #(
    parameter int N_SRC = 4,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel == SEL_W'(i)) tick = en[i];
        end
    end
endmodule

// File: rtl/pct_ctrl.sv
module pct_ctrl
    import pct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] mode_sel,
    input  logic       capture,
    output pct_state_e state,
    output logic       evt_run,
    output logic       meas_run,
    output logic       irq_ok
);
    pct_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!start) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (mode_sel == MODE_EVENT)     state_d = ST_EVENT;
                    else if (mode_sel == MODE_MEAS) state_d = ST_ARMED;
                end
                ST_EVENT: begin
                    if (mode_sel != MODE_EVENT) state_d = ST_IDLE;
                end
                ST_ARMED: begin
                    if (mode_sel != MODE_MEAS) state_d = ST_IDLE;
                    else if (capture)          state_d = ST_MEASURE;
                end
                ST_MEASURE: begin
                    if (mode_sel != MODE_MEAS) state_d = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        evt_run  = 1'b0;
        meas_run = 1'b0;
        irq_ok   = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_EVENT:   begin evt_run = 1'b1; irq_ok = 1'b1; end
            ST_ARMED:   meas_run = 1'b1;
            ST_MEASURE: begin meas_run = 1'b1; irq_ok = 1'b1; end
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/pulse_capture_timer.sv
module pulse_capture_timer
    import pct_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int N_SRC       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       reg_addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    input  logic             ext_in,
    input  logic [N_SRC-1:0] pre_en,
    output logic             irq,
    output logic             ovf
);
    localparam int SEL_W = $clog2(N_SRC);
    localparam logic [WIDTH-1:0] CNT_MAX = '1;

    logic [7:0]       mode_q;
    logic             start_q;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] rld_q;
    logic             ovf_q;
    logic             irq_q;

    logic       in_rise, in_fall, tick;
    logic       evt_edge, cap_edge;
    logic       evt_run, meas_run, irq_ok;
    pct_state_e state;

    logic wr_mode, wr_dat, wr_start;
    assign wr_mode  = wr_en && (reg_addr == ADDR_MODE);
    assign wr_dat   = wr_en && (reg_addr == ADDR_DATA);
    assign wr_start = wr_en && (reg_addr == ADDR_START);

    pct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_in),
        .rise     (in_rise),
        .fall     (in_fall)
    );

    pct_tick_sel #(.N_SRC(N_SRC)) u_tick (
        .en   (pre_en),
        .sel  (mode_q[7 -: SEL_W]),
        .tick (tick)
    );

    always_comb begin
        unique case (mode_q[3:2])
            2'b00:   evt_edge = in_fall;
            2'b01:   evt_edge = in_rise;
            2'b10:   evt_edge = in_rise | in_fall;
            default: evt_edge = 1'b0;
        endcase
        if (mode_q[3])      cap_edge = in_rise | in_fall;
        else if (mode_q[2]) cap_edge = in_rise;
        else                cap_edge = in_fall;
    end

    pct_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_q),
        .mode_sel (mode_q[1:0]),
        .capture  (cap_edge),
        .state    (state),
        .evt_run  (evt_run),
        .meas_run (meas_run),
        .irq_ok   (irq_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            start_q <= 1'b0;
        end else begin
            if (wr_mode)  mode_q  <= wr_data[7:0];
            if (wr_start) start_q <= wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rld_q <= '0;
            ovf_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (evt_run && evt_edge) begin
                if (cnt_q == '0) begin
                    cnt_q <= rld_q;
                    irq_q <= irq_ok;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else if (meas_run && cap_edge) begin
                rld_q <= cnt_q;
                cnt_q <= '0;
                irq_q <= irq_ok;
            end else if (meas_run && tick) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_MAX) ovf_q <= 1'b1;
            end
            if (wr_mode) ovf_q <= 1'b0;
            if (wr_dat) begin
                rld_q <= wr_data;
                if (state == ST_IDLE) cnt_q <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (reg_addr)
            ADDR_MODE: begin
                rd_data[7:0]   = mode_q;
                rd_data[OVF_BIT] = ovf_q;
            end
            ADDR_DATA:  rd_data = (mode_q[1:0] == MODE_MEAS) ? rld_q : cnt_q;
            ADDR_START: rd_data[0] = start_q;
            default:    rd_data = '0;
        endcase
    end

    assign irq = irq_q;
    assign ovf = ovf_q;
endmodule

// File: rtl/pct_checker.sv
module pct_checker
    import pct_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       reg_addr,
    input pct_state_e       state,
    input logic             evt_edge,
    input logic             cap_edge,
    input logic [WIDTH-1:0] cnt_q,
    input logic [WIDTH-1:0] rld_q,
    input logic             irq,
    input logic             ovf
);
    logic data_wr, mode_wr;
    assign data_wr = wr_en && (reg_addr == ADDR_DATA);
    assign mode_wr = wr_en && (reg_addr == ADDR_MODE);

    // R2
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !data_wr) |=> $stable(cnt_q));

    // R4
    evt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVENT && evt_edge && cnt_q == '0 && !data_wr)
        |=> (cnt_q == $past(rld_q) && irq));

    // R8
    cap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ARMED || state == ST_MEASURE) && cap_edge) |=> (cnt_q == '0));

    // R9
    arm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED) |=> !irq);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !mode_wr) |=> ovf);
endmodule

bind pulse_capture_timer pct_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .reg_addr (reg_addr),
    .state    (state),
    .evt_edge (evt_edge),
    .cap_edge (cap_edge),
    .cnt_q    (cnt_q),
    .rld_q    (rld_q),
    .irq      (irq),
    .ovf      (ovf)
);

// File: tb/pulse_capture_timer_tb.sv
module pulse_capture_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_data;
    logic        ext_in = 1'b0;
    logic [3:0]  pre_en = 4'd0;
    logic        irq, ovf;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;

    pulse_capture_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .ext_in(ext_in),
        .pre_en(pre_en), .irq(irq), .ovf(ovf)
    );

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n && irq) irq_seen++;

    // {edge select[1:0], reload[15:0], pulses[3:0], expected counter[15:0]}
    localparam logic [37:0] EVT_TAB [0:4] = '{
        {2'b00, 16'd100, 4'd3, 16'd97},
        {2'b01, 16'd50,  4'd4, 16'd46},
        {2'b10, 16'd20,  4'd3, 16'd14},
        {2'b11, 16'd9,   4'd5, 16'd9},
        {2'b01, 16'd7,   4'd1, 16'd6}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = rd_data;
    endtask

    task automatic set_in(input logic v);
        @(negedge clk);
        ext_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            set_in(1'b1);
            set_in(1'b0);
        end
    endtask

    task automatic ticks(input int idx, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pre_en[idx] = 1'b1;
            @(negedge clk); pre_en[idx] = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check("R1 mode", v, 16'd0);
        rd(2'd1, v); check("R1 data", v, 16'd0);
        rd(2'd2, v); check("R1 start", v, 16'd0);
        check("R1 irq/ovf", {14'd0, irq, ovf}, 16'd0);

        // R3 event edge selection table
        for (int k = 0; k < 5; k++) begin
            wr(2'd2, 16'd0);
            wr(2'd0, {12'd0, EVT_TAB[k][37:36], 2'b01});
            wr(2'd1, EVT_TAB[k][35:20]);
            wr(2'd2, 16'd1);
            repeat (3) @(negedge clk);
            pulses(int'(EVT_TAB[k][19:16]));
            rd(2'd1, v);
            check($sformatf("R3 edge table row %0d", k), v, EVT_TAB[k][15:0]);
        end

        // R2 stopped: no counting, write loads counter
        wr(2'd2, 16'd0);
        wr(2'd0, 16'h0005);
        wr(2'd1, 16'd30);
        rd(2'd1, v); check("R2 write loads counter", v, 16'd30);
        pulses(3);
        rd(2'd1, v); check("R2 stopped holds", v, 16'd30);

        // R11 synchronizer latency
        wr(2'd2, 16'd1);
        repeat (3) @(negedge clk);
        ext_in = 1'b1;
        repeat (2) @(negedge clk);
        rd(2'd1, v);  // third edge passes inside rd before sample
        check("R11 change after third edge", v, 16'd29);
        set_in(1'b0);

        // R4 underflow reload
        wr(2'd2, 16'd0);
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd1);
        repeat (3) @(negedge clk);
        base = irq_seen;
        pulses(2);
        rd(2'd1, v); check("R4 reaches zero", v, 16'd0);
        check("R4 no irq before wrap", 16'(irq_seen - base), 16'd0);
        pulses(1);
        rd(2'd1, v); check("R4 reload value", v, 16'd2);
        check("R4 irq on wrap", 16'(irq_seen - base), 16'd1);
        wr(2'd2, 16'd0);

        // R6 falling-to-falling, R5 source 1, R8, R9
        set_in(1'b1);
        wr(2'd0, 16'h0042);
        wr(2'd2, 16'd1);
        repeat (3) @(negedge clk);
        base = irq_seen;
        set_in(1'b0);
        check("R9 first capture quiet", 16'(irq_seen - base), 16'd0);
        ticks(1, 5); ticks(0, 3); ticks(2, 2);
        set_in(1'b1);
        ticks(1, 3);
        set_in(1'b0);
        rd(2'd1, v); check("R6 R5 fall period", v, 16'd8);
        check("R9 later capture irq", 16'(irq_seen - base), 16'd1);
        ticks(1, 2);
        set_in(1'b1);
        set_in(1'b0);
        rd(2'd1, v); check("R8 counter cleared", v, 16'd2);
        wr(2'd2, 16'd0);

        // R6 rising-to-rising, source 3
        wr(2'd0, 16'h00C6);
        wr(2'd2, 16'd1);
        repeat (3) @(negedge clk);
        set_in(1'b1);
        ticks(3, 6); ticks(1, 4);
        set_in(1'b0);
        set_in(1'b1);
        rd(2'd1, v); check("R6 R5 rise period", v, 16'd6);
        wr(2'd2, 16'd0);

        // R7 width measurement, source 0
        wr(2'd0, 16'h000A);
        wr(2'd2, 16'd1);
        repeat (3) @(negedge clk);
        base = irq_seen;
        set_in(1'b0);
        check("R9 width first quiet", 16'(irq_seen - base), 16'd0);
        ticks(0, 4);
        set_in(1'b1);
        rd(2'd1, v); check("R7 low width", v, 16'd4);
        ticks(0, 7);
        set_in(1'b0);
        rd(2'd1, v); check("R7 high width", v, 16'd7);
        check("R7 irq count", 16'(irq_seen - base), 16'd2);
        wr(2'd2, 16'd0);

        // R10 overflow
        wr(2'd0, 16'h0002);
        wr(2'd1, 16'hFFFE);
        wr(2'd2, 16'd1);
        repeat (3) @(negedge clk);
        ticks(0, 1);
        @(negedge clk);
        check("R10 no ovf yet", {15'd0, ovf}, 16'd0);
        ticks(0, 1);
        @(negedge clk);
        check("R10 ovf set", {15'd0, ovf}, 16'd1);
        rd(2'd0, v); check("R10 ovf readback", {15'd0, v[5]}, 16'd1);
        ticks(0, 2);
        check("R10 ovf sticky", {15'd0, ovf}, 16'd1);
        wr(2'd0, 16'h0002);
        @(negedge clk);
        check("R10 ovf cleared", {15'd0, ovf}, 16'd0);
        wr(2'd2, 16'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule